// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block produces one pulse-width modulated output from a single 32-bit control word. A write port loads the whole word in one cycle, and the word can be read back unchanged. A programmable prescaler turns the source clock into a slower step rate. An 8-bit phase counter advances by one on each step, so every output period is 256 steps long. The output period is therefore 256·(SCALE+1) source clocks.

Three fields shape the waveform: an 8-bit duty value, a force-high bit and an enable bit. Any write restarts the period at once, and the period in progress is abandoned. Clearing the enable bit drives the output low on the next cycle. A one-cycle strobe marks the start of each new period, so a period can be measured from outside.

Top module: `pwm_prescaled`

## Requirements
- R1: A synchronous active-high reset clears the control word to zero, holds `pwm_out` low and holds `period_start` low.
- R2: When `wr_en` is high at a clock edge, all 32 bits of `wr_data` are stored, and `rd_data` returns them from the next cycle onwards.
- R3: The phase counter advances once every SCALE+1 source clocks, where SCALE is control bits [12:0]. SCALE = 0 gives one step per clock.
- R4: An enabled output repeats with a period of exactly 256·(SCALE+1) clocks. `period_start` is high for one cycle in the cycle where the phase returns to zero, and it is not high in the first cycle after a write.
- R5: In an enabled period, with bit 24 clear, `pwm_out` is high while the phase is below DUTY (control bits [23:16]). After a write, the output is high for the first DUTY·(SCALE+1) clocks of each period and low for the rest. DUTY = 0 gives a constant low output.
- R6: With bit 24 set and the block enabled, `pwm_out` stays high in every cycle, whatever the value of DUTY.
- R7: With the enable bit (bit 31) clear, `pwm_out` and `period_start` are low from the cycle after the write that cleared it.
- R8: Any write, including one made in the middle of a period, restarts the prescaler and the phase at zero. The new waveform begins in the cycle after the write.
- R9: Bits 30:25 and 15:13 are stored and read back, but they have no effect on `pwm_out` or `period_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Loads `wr_data` into the control word |
| wr_data | input | 32 | New control word |
| rd_data | output | 32 | Stored control word |
| pwm_out | output | 1 | Modulated output |
| period_start | output | 1 | One-cycle strobe when a period begins |

## Verification
A prescaler that drifts from the SCALE+1 count stretches or shortens every duty step. The error shows within the first high time after a write, which lasts DUTY·(SCALE+1) clocks. A phase counter that skips or sticks moves the falling edge, and it also moves the `period_start` strobe away from the 256·(SCALE+1) mark. A missing restart on a write shows in the first cycle after the write, because the output then keeps the old phase. The bench sweeps every DUTY value at SCALE = 0 and compares every cycle against values it works out arithmetically. It also covers several small SCALE values, rewrites made in the middle of a period, disable, the force-high bit and the unused bits.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    parameter int unsigned CTRL_W   = 32;
    parameter int unsigned SCALE_W  = 13;
    parameter int unsigned PHASE_W  = 8;
    parameter int unsigned DUTY_LSB = 16;
    parameter int unsigned FULL_BIT = 24;
    parameter int unsigned EN_BIT   = 31;

    typedef struct packed {
        logic               en;
        logic               full;
        logic [PHASE_W-1:0] duty;
        logic [SCALE_W-1:0] scale;
    } pwm_cfg_t;

    function automatic pwm_cfg_t cfg_decode(input logic [CTRL_W-1:0] w);
        pwm_cfg_t c;
        c.en    = w[EN_BIT];
        c.full  = w[FULL_BIT];
        c.duty  = w[DUTY_LSB +: PHASE_W];
        c.scale = w[SCALE_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] word_q,
    output pwm_cfg_t          cfg
);
    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.word = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_q = st_q.word;
    assign cfg    = cfg_decode(st_q.word);

    // R2: a write is visible on the next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (word_q == $past(wr_data)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned SCALE_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick,
    output logic [SCALE_W-1:0] count
);
    typedef struct packed {
        logic [SCALE_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = (st_q.cnt == scale);
        tick     = run && at_limit;
        if (restart || !run) st_d.cnt = '0;
        else if (at_limit)   st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R3: the divider never runs past the programmed limit
    a_r3_presc_bound: assert property (@(posedge clk) disable iff (rst)
        count <= scale);
endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               run,
    input  logic               tick,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap
);
    localparam logic [PHASE_W-1:0] PHASE_MAX = '1;

    typedef struct packed {
        logic [PHASE_W-1:0] ph;
        logic               wrap;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (restart || !run) begin
            st_d.ph = '0;
        end else if (tick) begin
            st_d.ph   = st_q.ph + 1'b1;
            st_d.wrap = (st_q.ph == PHASE_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign wrap  = st_q.wrap;

    // R3: one step per tick when running without restart
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !restart) |=> (phase == $past(phase) + 1'b1));
    // R4: the strobe coincides with phase zero
    a_r4_wrap_phase: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (phase == '0));
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              period_start
);
    pwm_cfg_t           cfg;
    logic               tick;
    logic [SCALE_W-1:0] presc_cnt;
    logic [PHASE_W-1:0] phase;
    logic               wrap;

    pwm_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_q  (rd_data),
        .cfg     (cfg)
    );

    pwm_prescaler #(.SCALE_W(SCALE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .run     (cfg.en),
        .scale   (cfg.scale),
        .tick    (tick),
        .count   (presc_cnt)
    );

    pwm_phase_counter #(.PHASE_W(PHASE_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .run     (cfg.en),
        .tick    (tick),
        .phase   (phase),
        .wrap    (wrap)
    );

    always_comb begin
        pwm_out      = cfg.en && (cfg.full || (phase < cfg.duty));
        period_start = cfg.en && wrap;
    end

    // R8: every write restarts both counters
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (phase == '0 && presc_cnt == '0));
    // R7: a write that clears the enable silences both outputs
    a_r7_disable_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[EN_BIT]) |=> (!pwm_out && !period_start));
    // R6: a write with enable and force-high gives a high output next cycle
    a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[EN_BIT] && wr_data[FULL_BIT]) |=> pwm_out);
    // R1: outputs are quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pwm_out && !period_start && rd_data == '0));
endmodule

// File: tb/pwm_prescaled_tb_top.sv
module pwm_prescaled_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    logic        period_start;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_prescaled dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    function automatic logic [31:0] mk(input bit en, input bit full,
                                        input int duty, input int scale);
        return {en, 6'b0, full, duty[7:0], 3'b0, scale[12:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // leaves the bench at the first falling edge after the write edge (k = 0)
    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 readback", rd_data, w);
    endtask

    task automatic run_window(input int n, input logic [31:0] w, input string req);
        bit en   = w[31];
        bit full = w[24];
        int duty = int'(w[23:16]);
        int s    = int'(w[12:0]);
        int per  = 256 * (s + 1);
        for (int k = 0; k < n; k++) begin
            bit exp_pwm;
            bit exp_ps;
            if (k > 0) @(negedge clk);
            exp_pwm = en && (full || (((k / (s + 1)) % 256) < duty));
            exp_ps  = en && (k > 0) && ((k % per) == 0);
            chk({req, " pwm_out"}, {31'b0, pwm_out}, {31'b0, exp_pwm});
            chk("R4 period_start", {31'b0, period_start}, {31'b0, exp_ps});
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 pwm_out", {31'b0, pwm_out}, 32'h0);
        chk("R1 period_start", {31'b0, period_start}, 32'h0);
        rst = 1'b0;

        // R5 exhaustive duty sweep at SCALE = 0, a little over one period each
        for (int d = 0; d < 256; d++) begin
            write_cfg(mk(1'b1, 1'b0, d, 0));
            run_window(258, mk(1'b1, 1'b0, d, 0), "R5 duty");
        end

        // R3 / R4 small prescaler values, two periods each
        for (int s = 1; s <= 3; s++) begin
            write_cfg(mk(1'b1, 1'b0, 1, s));
            run_window(2 * 256 * (s + 1) + 2, mk(1'b1, 1'b0, 1, s), "R3 scale");
            write_cfg(mk(1'b1, 1'b0, 200, s));
            run_window(256 * (s + 1) + 2, mk(1'b1, 1'b0, 200, s), "R3 scale");
        end

        // R6 force-high ignores duty, including DUTY = 0
        write_cfg(mk(1'b1, 1'b1, 0, 0));
        run_window(600, mk(1'b1, 1'b1, 0, 0), "R6 full");
        write_cfg(mk(1'b1, 1'b1, 77, 2));
        run_window(800, mk(1'b1, 1'b1, 77, 2), "R6 full");

        // R8 rewrite in the middle of a period
        write_cfg(mk(1'b1, 1'b0, 100, 1));
        run_window(150, mk(1'b1, 1'b0, 100, 1), "R8 before");
        write_cfg(mk(1'b1, 1'b0, 30, 2));
        run_window(800, mk(1'b1, 1'b0, 30, 2), "R8 rewrite");
        // same word again mid-high-time still restarts the period
        run_window(40, mk(1'b1, 1'b0, 30, 2), "R8 pre");
        write_cfg(mk(1'b1, 1'b0, 30, 2));
        run_window(200, mk(1'b1, 1'b0, 30, 2), "R8 same word");

        // R7 disable while high, with force-high and duty set
        write_cfg(mk(1'b1, 1'b1, 255, 0));
        run_window(10, mk(1'b1, 1'b1, 255, 0), "R7 before");
        write_cfg(mk(1'b0, 1'b1, 255, 0));
        run_window(600, mk(1'b0, 1'b1, 255, 0), "R7 disabled");
        // R7 re-enable starts a fresh period
        write_cfg(mk(1'b1, 1'b0, 5, 0));
        run_window(300, mk(1'b1, 1'b0, 5, 0), "R7 reenable");

        // R9 unused bits are stored but do not change the waveform
        begin
            logic [31:0] w = mk(1'b1, 1'b0, 60, 1) | 32'h7E00_E000;
            write_cfg(w);
            run_window(520, w, "R9 unused bits");
            w = mk(1'b0, 1'b0, 60, 1) | 32'h7E00_E000;
            write_cfg(w);
            run_window(100, w, "R9 unused bits off");
        end

        // R1 reset in the middle of operation
        write_cfg(mk(1'b1, 1'b1, 9, 0));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 pwm_out", {31'b0, pwm_out}, 32'h0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule